// File: doc/BRIEF.md
# Accumulator Processor Core with Interrupt Cycle

This block is a small processor core built around one accumulator. It steps through a fixed loop of named states. FETCH puts the program counter on a synchronous word-addressed memory port. DECODE captures the returned word into the instruction register and advances the program counter. EXEC carries out the operation. OPREAD takes in operand data for the two instructions that read memory. IRQCHK closes every instruction by sampling the interrupt machinery. The memory returns read data one clock after the request and accepts a write in the cycle its write strobe is high.

Interrupt requests arrive as single-cycle pulses on `irq_req`. A small counter holds them. In IRQCHK, a nonzero count with interrupts enabled has four effects: one pulse on `irq_ack`, the current program counter and carry flag copied into shadow registers, interrupts masked, and the next fetch taken from the fixed handler address. The return opcode copies both shadow values back and lifts the mask. Pulses that arrive while the handler runs stay counted. Each is serviced in turn after the return.

The transitions are: FETCH to DECODE; DECODE to EXEC; EXEC to OPREAD for load and add; EXEC to IRQCHK for every other opcode; OPREAD to IRQCHK; and IRQCHK to FETCH. The last of these either enters the handler or does not.

Top module: `acc_core`

## Requirements
- R1: While `rst_n` is low, `mem_we`, `irq_ack` and `carry_flag` are 0. The first memory read after reset is the fetch of address 0x000.
- R2: An instruction is one 16-bit word: opcode in bits 15:12, address operand in bits 11:0. Read data returns one cycle after `mem_re`. Unless the instruction redirects it, the program counter advances by one per instruction.
- R3: Opcode 0001 (load) copies the word at the operand address into the accumulator and leaves the carry flag unchanged.
- R4: Opcode 0101 (add) adds the word at the operand address to the accumulator modulo 2^16. The carry flag is set to the carry out of bit 15.
- R5: Opcode 0010 (store) writes the accumulator to the operand address with `mem_we` high for one cycle. `mem_we` and `mem_re` are never high together.
- R6: Opcode 1000 (jump) sets the program counter to the operand address. Opcodes 0000, 0011, 0100, 0110, 0111 and 1001 through 1110 do nothing: no memory access, and no change to the accumulator or the carry flag.
- R7: In IRQCHK, a pending request with interrupts enabled raises `irq_ack` for one cycle. No memory access takes place in that cycle. The next cycle fetches from 0x100.
- R8: Interrupt entry saves the address of the next instruction and the carry flag. Opcode 1111 (return) restores both and re-enables interrupts.
- R9: From entry until the return, no new entry occurs. Up to three `irq_req` pulses are counted meanwhile, and each produces exactly one later entry.
- R10: Instructions that do not read operand data take 4 cycles from fetch to fetch. Load and add take 5 cycles, and their operand read comes 2 cycles after their fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 12 | Word address for fetch, operand read or store |
| mem_re | output | 1 | Read request; data due on `mem_rdata` next cycle |
| mem_we | output | 1 | Write strobe for `mem_wdata` at `mem_addr` |
| mem_wdata | output | 16 | Accumulator value being stored |
| mem_rdata | input | 16 | Read data from memory, one cycle after request |
| irq_req | input | 1 | Interrupt request pulse, one per event |
| irq_ack | output | 1 | One-cycle pulse when the handler is entered |
| carry_flag | output | 1 | Current carry flag |

## Verification
Every result has a fixed latency from the fetch strobe. A plain instruction spans four cycles. Load and add read their operand two cycles after the fetch, and the next fetch follows three cycles after that. A store's write strobe appears two cycles after its fetch. The handler fetch comes one cycle after `irq_ack`.

The bench logs the cycle number and address of every read request and compares the gaps against these counts. It waits for a store's own strobe, or for a particular fetch address, before it samples memory or the carry flag, so no check relies on a guessed delay. Masking is checked by counting acknowledges inside a window that ends before the handler's return can execute. The queued services are counted only after enough cycles for all of them to finish.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] OPC_LOAD  = 4'b0001;
    localparam logic [OP_W-1:0] OPC_STORE = 4'b0010;
    localparam logic [OP_W-1:0] OPC_ADD   = 4'b0101;
    localparam logic [OP_W-1:0] OPC_JUMP  = 4'b1000;
    localparam logic [OP_W-1:0] OPC_RETI  = 4'b1111;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_OPREAD,
        ST_IRQCHK
    } core_state_e;

    typedef struct packed {
        logic mem_re;
        logic mem_we;
        logic addr_from_ir;
        logic ir_load;
        logic pc_inc;
        logic pc_jump;
        logic pc_vector;
        logic pc_restore;
        logic ac_load;
        logic ac_add;
        logic take_irq;
        logic do_reti;
    } core_ctrl_t;

endpackage

// File: rtl/acc_ctrl.sv
module acc_ctrl
    import acc_core_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] opcode,
    input  logic            irq_ok,
    output core_ctrl_t      ctl
);

    core_state_e state;
    core_state_e state_nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FETCH;
        else        state <= state_nxt;
    end

    // next state and control outputs
    always_comb begin
        ctl       = '0;
        state_nxt = state;
        unique case (state)
            ST_FETCH: begin
                ctl.mem_re = 1'b1;
                state_nxt  = ST_DECODE;
            end
            ST_DECODE: begin
                ctl.ir_load = 1'b1;
                ctl.pc_inc  = 1'b1;
                state_nxt   = ST_EXEC;
            end
            ST_EXEC: begin
                state_nxt = ST_IRQCHK;
                case (opcode)
                    OPC_LOAD, OPC_ADD: begin
                        ctl.mem_re       = 1'b1;
                        ctl.addr_from_ir = 1'b1;
                        state_nxt        = ST_OPREAD;
                    end
                    OPC_STORE: begin
                        ctl.mem_we       = 1'b1;
                        ctl.addr_from_ir = 1'b1;
                    end
                    OPC_JUMP: ctl.pc_jump = 1'b1;
                    OPC_RETI: begin
                        ctl.pc_restore = 1'b1;
                        ctl.do_reti    = 1'b1;
                    end
                    default: ;
                endcase
            end
            ST_OPREAD: begin
                ctl.ac_load = (opcode == OPC_LOAD);
                ctl.ac_add  = (opcode == OPC_ADD);
                state_nxt   = ST_IRQCHK;
            end
            ST_IRQCHK: begin
                if (irq_ok) begin
                    ctl.take_irq  = 1'b1;
                    ctl.pc_vector = 1'b1;
                end
                state_nxt = ST_FETCH;
            end
            default: state_nxt = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/acc_irq_unit.sv
module acc_irq_unit #(
    parameter int ADDR_W = 12,
    parameter int PEND_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_req,
    input  logic              take,
    input  logic              reti,
    input  logic [ADDR_W-1:0] pc_now,
    input  logic              carry_now,
    output logic              irq_ok,
    output logic              irq_en,
    output logic [ADDR_W-1:0] ret_pc,
    output logic              ret_carry
);

    localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

    logic [PEND_W-1:0] pend_cnt;
    logic              inc;

    assign inc    = irq_req && (pend_cnt != PEND_MAX);
    assign irq_ok = irq_en && (pend_cnt != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_cnt  <= '0;
            irq_en    <= 1'b1;
            ret_pc    <= '0;
            ret_carry <= 1'b0;
        end else begin
            pend_cnt <= pend_cnt + PEND_W'(inc) - PEND_W'(take);
            if (take) begin
                irq_en    <= 1'b0;
                ret_pc    <= pc_now;
                ret_carry <= carry_now;
            end else if (reti) begin
                irq_en <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
    import acc_core_pkg::*;
#(
    parameter int                ADDR_W = 12,
    parameter int                DATA_W = 16,
    parameter logic [ADDR_W-1:0] VECTOR = 12'h100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  core_ctrl_t        ctl,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [ADDR_W-1:0] ret_pc,
    input  logic              ret_carry,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [OP_W-1:0]   opcode,
    output logic [ADDR_W-1:0] pc,
    output logic              carry
);

    logic [DATA_W-1:0] ir;
    logic [DATA_W-1:0] ac;
    logic [DATA_W:0]   sum;

    assign sum       = {1'b0, ac} + {1'b0, mem_rdata};
    assign opcode    = ir[DATA_W-1 -: OP_W];
    assign mem_addr  = ctl.addr_from_ir ? ir[ADDR_W-1:0] : pc;
    assign mem_wdata = ac;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc    <= '0;
            ir    <= '0;
            ac    <= '0;
            carry <= 1'b0;
        end else begin
            if (ctl.ir_load) ir <= mem_rdata;

            if (ctl.pc_vector)       pc <= VECTOR;
            else if (ctl.pc_restore) pc <= ret_pc;
            else if (ctl.pc_jump)    pc <= ir[ADDR_W-1:0];
            else if (ctl.pc_inc)     pc <= pc + ADDR_W'(1);

            if (ctl.ac_load) ac <= mem_rdata;
            else if (ctl.ac_add) ac <= sum[DATA_W-1:0];

            if (ctl.ac_add)       carry <= sum[DATA_W];
            else if (ctl.do_reti) carry <= ret_carry;
        end
    end

endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_core_pkg::*;
#(
    parameter int          ADDR_W       = 12,
    parameter int unsigned HANDLER_ADDR = 'h100,
    parameter int          PEND_W       = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic                     mem_re,
    output logic                     mem_we,
    output logic [OP_W+ADDR_W-1:0]   mem_wdata,
    input  logic [OP_W+ADDR_W-1:0]   mem_rdata,
    input  logic                     irq_req,
    output logic                     irq_ack,
    output logic                     carry_flag
);

    localparam int                DATA_W = OP_W + ADDR_W;
    localparam logic [ADDR_W-1:0] VECTOR = ADDR_W'(HANDLER_ADDR);

    core_ctrl_t        ctl;
    logic [OP_W-1:0]   opcode;
    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] ret_pc;
    logic              ret_carry;
    logic              irq_ok;
    logic              irq_en;

    acc_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (opcode),
        .irq_ok (irq_ok),
        .ctl    (ctl)
    );

    acc_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .VECTOR (VECTOR)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .ret_pc    (ret_pc),
        .ret_carry (ret_carry),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .opcode    (opcode),
        .pc        (pc),
        .carry     (carry_flag)
    );

    acc_irq_unit #(
        .ADDR_W (ADDR_W),
        .PEND_W (PEND_W)
    ) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_req   (irq_req),
        .take      (ctl.take_irq),
        .reti      (ctl.do_reti),
        .pc_now    (pc),
        .carry_now (carry_flag),
        .irq_ok    (irq_ok),
        .irq_en    (irq_en),
        .ret_pc    (ret_pc),
        .ret_carry (ret_carry)
    );

    assign mem_re  = ctl.mem_re;
    assign mem_we  = ctl.mem_we;
    assign irq_ack = ctl.take_irq;

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
    parameter int          ADDR_W       = 12,
    parameter int unsigned HANDLER_ADDR = 'h100
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_re,
    input logic              mem_we,
    input logic              irq_ack,
    input logic              irq_en
);

    // R5: store strobe never overlaps a read request
    a_r5_we_excl_re: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !mem_re);

    // R7: handler fetch follows the acknowledge
    a_r7_vector_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> (mem_re && mem_addr == ADDR_W'(HANDLER_ADDR)));

    // R7: no memory traffic during the acknowledge cycle
    a_r7_ack_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> (!mem_re && !mem_we));

    // R9: entry masks further interrupts
    a_r9_mask_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_en);

    // R9: no back-to-back entries
    a_r9_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_ack);

    // R10: a read is always followed by a cycle without a read
    a_r10_read_gap: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> !mem_re);

endmodule

bind acc_core acc_core_chk #(
    .ADDR_W       (ADDR_W),
    .HANDLER_ADDR (HANDLER_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_addr (mem_addr),
    .mem_re   (mem_re),
    .mem_we   (mem_we),
    .irq_ack  (irq_ack),
    .irq_en   (irq_en)
);

// File: tb/acc_core_tb.sv
module acc_core_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic        mem_re;
    logic        mem_we;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        irq_req = 1'b0;
    logic        irq_ack;
    logic        carry_flag;

    logic [15:0] mem [0:1023];
    int          cyc = 0;
    int          checks = 0;
    int          fails = 0;
    int          nlog;
    logic [11:0] log_addr [0:15];
    int          log_cyc  [0:15];
    int          acks;

    always #4 clk = ~clk;

    acc_core u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mem_addr   (mem_addr),
        .mem_re     (mem_re),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .irq_req    (irq_req),
        .irq_ack    (irq_ack),
        .carry_flag (carry_flag)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[9:0]];
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            nlog <= 0;
            acks <= 0;
        end else begin
            if (mem_re && nlog < 16) begin
                log_addr[nlog] <= mem_addr;
                log_cyc[nlog]  <= cyc;
                nlog           <= nlog + 1;
            end
            if (irq_ack) acks <= acks + 1;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_eq(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic start_prog();
        @(negedge clk);
        rst_n   = 1'b0;
        irq_req = 1'b0;
        for (int i = 0; i < 1024; i++) mem[i] <= 16'h0000;
        tick(1);
    endtask

    task automatic put(input int a, input logic [15:0] w);
        mem[a] <= w;
    endtask

    task automatic release_rst();
        tick(2);
        rst_n = 1'b1;
    endtask

    task automatic pulse_irq();
        @(negedge clk);
        irq_req = 1'b1;
        @(negedge clk);
        irq_req = 1'b0;
    endtask

    task automatic wait_store(input logic [11:0] a);
        int t = 0;
        while (!(mem_we && mem_addr == a) && t < 200) begin
            @(negedge clk);
            t++;
        end
        check_eq("R5", "store strobe seen", int'(mem_we && mem_addr == a), 1);
        tick(1);
    endtask

    // main program shared by the interrupt scenarios, handler at 0x100
    task automatic load_irq_prog();
        put(12'h000, 16'h1240);   // LOAD 0x240
        put(12'h001, 16'h5221);   // ADD 0x221
        put(12'h002, 16'h2241);   // STORE 0x241
        put(12'h003, 16'h8003);   // JUMP 3
        put(12'h240, 16'hFFFF);
        put(12'h221, 16'h0001);
        put(12'h241, 16'h5555);
        put(12'h100, 16'h223F);   // STORE 0x23F
        put(12'h101, 16'h1230);   // LOAD 0x230
        put(12'h102, 16'h5221);   // ADD 0x221
        put(12'h103, 16'h2230);   // STORE 0x230
        put(12'h104, 16'h123F);   // LOAD 0x23F
        put(12'h105, 16'hF000);   // RETURN
    endtask

    task automatic t_reset_and_timing();
        start_prog();
        put(12'h000, 16'h3ABC);   // NOP (opcode 0011)
        put(12'h001, 16'h1200);   // LOAD 0x200
        put(12'h002, 16'h8000);   // JUMP 0
        put(12'h200, 16'h00AA);
        tick(1);
        check_eq("R1", "mem_we in reset", int'(mem_we), 0);
        check_eq("R1", "irq_ack in reset", int'(irq_ack), 0);
        check_eq("R1", "carry in reset", int'(carry_flag), 0);
        release_rst();
        tick(20);
        check_eq("R1", "first fetch address", int'(log_addr[0]), 0);
        check_eq("R10", "nop fetch-to-fetch", log_cyc[1] - log_cyc[0], 4);
        check_eq("R6", "nop makes no access", int'(log_addr[1]), 1);
        check_eq("R10", "operand read offset", log_cyc[2] - log_cyc[1], 2);
        check_eq("R2", "operand address field", int'(log_addr[2]), 12'h200);
        check_eq("R10", "load fetch-to-fetch", log_cyc[3] - log_cyc[1], 5);
        check_eq("R2", "pc increments", int'(log_addr[3]), 2);
        check_eq("R6", "jump target fetch", int'(log_addr[4]), 0);
        check_eq("R10", "jump fetch-to-fetch", log_cyc[4] - log_cyc[3], 4);
    endtask

    task automatic t_load_add_store();
        start_prog();
        put(12'h000, 16'h1200);   // LOAD 0x200
        put(12'h001, 16'h5201);   // ADD 0x201
        put(12'h002, 16'h2202);   // STORE 0x202
        put(12'h003, 16'h1203);   // LOAD 0x203
        put(12'h004, 16'h2204);   // STORE 0x204
        put(12'h005, 16'h5205);   // ADD 0x205
        put(12'h006, 16'h2206);   // STORE 0x206
        put(12'h007, 16'h8007);   // JUMP 7
        put(12'h200, 16'h8000);
        put(12'h201, 16'h8001);
        put(12'h203, 16'h1234);
        put(12'h205, 16'h0001);
        release_rst();
        wait_store(12'h202);
        check_eq("R4", "wrapped sum", int'(mem[12'h202]), 16'h0001);
        check_eq("R4", "carry out set", int'(carry_flag), 1);
        wait_store(12'h204);
        check_eq("R3", "loaded value", int'(mem[12'h204]), 16'h1234);
        check_eq("R3", "load keeps carry", int'(carry_flag), 1);
        wait_store(12'h206);
        check_eq("R4", "plain sum", int'(mem[12'h206]), 16'h1235);
        check_eq("R4", "carry cleared", int'(carry_flag), 0);
    endtask

    task automatic t_jump_nop();
        start_prog();
        put(12'h000, 16'h8004);   // JUMP 4
        put(12'h001, 16'h2210);   // STORE 0x210 (skipped)
        put(12'h004, 16'h1200);   // LOAD 0x200
        put(12'h005, 16'h3FFF);   // NOP (opcode 0011)
        put(12'h006, 16'hE123);   // NOP (opcode 1110)
        put(12'h007, 16'h2211);   // STORE 0x211
        put(12'h008, 16'h8008);   // JUMP 8
        put(12'h200, 16'h00AA);
        put(12'h210, 16'hDEAD);
        release_rst();
        wait_store(12'h211);
        check_eq("R6", "nops keep accumulator", int'(mem[12'h211]), 16'h00AA);
        check_eq("R6", "jumped-over store", int'(mem[12'h210]), 16'hDEAD);
        check_eq("R6", "nops keep carry", int'(carry_flag), 0);
    endtask

    task automatic t_single_irq();
        int t;
        start_prog();
        load_irq_prog();
        release_rst();
        wait_store(12'h241);
        check_eq("R4", "carry before interrupt", int'(carry_flag), 1);
        check_eq("R4", "sum before interrupt", int'(mem[12'h241]), 0);
        pulse_irq();
        t = 0;
        while (!irq_ack && t < 30) begin @(negedge clk); t++; end
        check_eq("R7", "ack raised", int'(irq_ack), 1);
        tick(1);
        check_eq("R7", "handler fetch", int'(mem_re && mem_addr == 12'h100), 1);
        t = 0;
        while (!(mem_re && mem_addr == 12'h105) && t < 60) begin @(negedge clk); t++; end
        check_eq("R8", "carry inside handler", int'(carry_flag), 0);
        tick(1);
        t = 0;
        while (!mem_re && t < 10) begin @(negedge clk); t++; end
        check_eq("R8", "return address", int'(mem_addr), 3);
        check_eq("R8", "carry restored", int'(carry_flag), 1);
        check_eq("R7", "handler ran once", int'(mem[12'h230]), 1);
        check_eq("R7", "ack count", acks, 1);
    endtask

    task automatic t_queued_irq();
        int t;
        start_prog();
        load_irq_prog();
        release_rst();
        wait_store(12'h241);
        pulse_irq();
        t = 0;
        while (!irq_ack && t < 30) begin @(negedge clk); t++; end
        tick(3);
        pulse_irq();
        tick(2);
        pulse_irq();
        tick(12);
        check_eq("R9", "masked while handler runs", acks, 1);
        tick(150);
        check_eq("R9", "queued entries serviced", acks, 3);
        check_eq("R9", "handler run count", int'(mem[12'h230]), 3);
        check_eq("R8", "carry after queued returns", int'(carry_flag), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset_and_timing();
        t_load_add_store();
        t_jump_nop();
        t_single_irq();
        t_queued_irq();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule